// File: doc/BRIEF.md
# Two-Wire Bus Register Slave

This block is a slave on a two-wire (clock plus bidirectional data) control bus. It runs entirely on a fast system clock and treats both bus wires as ordinary inputs. Each wire first passes through a synchronizer and a pulse filter. The filter discards any level change that does not persist for a set number of system cycles. The slave then frames the traffic and answers only its own 7-bit address.

After a write address, the first data byte loads an internal register pointer. Every later byte is written to a byte-wide register port at that pointer, and the pointer then increments. After a read address, the slave fetches a byte from the register port at each acknowledge point and returns it most significant bit first. The pointer increments after each fetch.

The data wire is open-drain. The slave only ever pulls it low or lets it go. Every change the slave makes to the wire is held back by a programmed number of system cycles after the bus clock falls. This gives the master a guaranteed data hold time.

Top module: `tw_slave`

## Requirements
- R1: After reset the data wire is released (`sdaOe` = 0) and neither `regWrEn` nor `regRdEn` is asserted.
- R2: A START is a falling data wire while the bus clock is high; it always restarts address reception. A STOP is a rising data wire while the bus clock is high; it abandons any transfer in progress, so a byte cut short by a STOP causes no register write.
- R3: The first byte after START holds the address in bits 7..1 (sent bit 7 first) and the direction in bit 0 (1 = read). When bits 7..1 equal `SLV_ADDR`, the slave pulls the data wire low during the ninth clock.
- R4: When the address does not match, the slave never pulls the data wire and makes no register access until the next START.
- R5: In a write, the first data byte sets the pointer. Each later byte, received bit 7 first, produces one `regWrEn` pulse with `regAddr` = pointer and `regWrData` = the byte, and the pointer then increments. Every data byte is acknowledged by a low data wire in its ninth clock.
- R6: In a read, at each acknowledge point the slave pulses `regRdEn` with `regAddr` = pointer, captures `regRdData`, increments the pointer, and shifts the byte out bit 7 first. A read continues from wherever the pointer was left by earlier transfers.
- R7: A high data wire in the master's acknowledge slot of a read makes the slave release the wire. It then ignores all clocks, with no pulls and no reads, until a STOP or START.
- R8: A level change on either bus input shorter than `FILT_CYC` system cycles has no effect on framing, received data or acknowledges.
- R9: After the bus clock falls, `sdaOe` keeps its value for at least `HOLD_CYC` system cycles.
- R10: While the bus clock stays high, `sdaOe` never goes from 0 to 1.
- R11: A repeated START during a write (no STOP in between) is accepted and begins a new addressed transfer that keeps the pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| sclIn | input | 1 | Bus clock wire level |
| sdaIn | input | 1 | Bus data wire level |
| sdaOe | output | 1 | 1 pulls the data wire low, 0 releases it |
| regAddr | output | PTR_W | Register port address (the pointer) |
| regWrEn | output | 1 | One-cycle register write strobe |
| regWrData | output | 8 | Register write data |
| regRdEn | output | 1 | One-cycle register read strobe |
| regRdData | input | 8 | Register read data, valid in the `regRdEn` cycle |

## Verification
The hardest case to reach from the ports is a short pulse that would look like a real bus event. Two examples are a brief data-wire dip while the clock is high, which mimics a START followed by a STOP, and a short clock spike during a low phase, which would add an extra bit. The bench drives separate glitch wires that are combined with the master's wires. During one write, it injects both kinds of pulse into every data bit. It then checks the acknowledges and the register writes, and reads the bytes back.

A second hard case is a master NACK followed by more clocks. The bench sends a full extra byte of clocks after the NACK and checks that the slave neither pulls the wire nor reads a register.

// File: rtl/tw_pkg.sv
package tw_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_AACK, ST_WR, ST_WACK, ST_RD, ST_RACK, ST_WAIT
  } twState_t;

  // strobes from control to datapath, at most one drive decision per cycle
  typedef struct packed {
    logic shiftIn;
    logic loadRead;
    logic shiftOut;
    logic ackLow;
    logic relBus;
    logic setPtr;
    logic wrReg;
    logic abort;
  } twCmd_t;
endpackage

// File: rtl/tw_glitch_filter.sv
module tw_glitch_filter #(
  parameter int FILT_CYC = 5
) (
  input  logic clk,
  input  logic rstN,
  input  logic rawIn,
  output logic cleanOut
);
  localparam int CW = $clog2(FILT_CYC + 1);

  logic [1:0]    syncQ;
  logic [CW-1:0] runCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncQ    <= 2'b11;
      cleanOut <= 1'b1;
      runCnt   <= '0;
    end else begin
      syncQ <= {syncQ[0], rawIn};
      if (syncQ[1] == cleanOut) begin
        runCnt <= '0;
      end else if (runCnt == CW'(FILT_CYC - 1)) begin
        cleanOut <= syncQ[1];
        runCnt   <= '0;
      end else begin
        runCnt <= runCnt + 1'b1;
      end
    end
  end

  if (FILT_CYC >= 2) begin : gGap
    // R8
    filt_min_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
      !$stable(cleanOut) |=> $stable(cleanOut));
  end
endmodule

// File: rtl/tw_ctrl.sv
module tw_ctrl
  import tw_pkg::*;
#(
  parameter logic [6:0] SLV_ADDR = 7'h2A
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclF,
  input  logic              sdaF,
  input  logic [BYTE_W-1:0] shByte,
  output twCmd_t            cmd
);
  twState_t   st, stNext;
  logic [3:0] bitCnt, cntNext;
  logic       sclD, sdaD;
  logic       rwBit, rwNext;
  logic       firstWr, firstNext;
  logic       mNack, mNackNext;
  logic       sclRise, sclFall, startDet, stopDet;

  assign sclRise  = sclF & ~sclD;
  assign sclFall  = ~sclF & sclD;
  assign startDet = sclF & sclD & sdaD & ~sdaF;
  assign stopDet  = sclF & sclD & ~sdaD & sdaF;

  always_comb begin
    cmd       = '0;
    stNext    = st;
    cntNext   = bitCnt;
    rwNext    = rwBit;
    firstNext = firstWr;
    mNackNext = mNack;
    if (startDet) begin
      stNext    = ST_ADDR;
      cntNext   = 4'd0;
      cmd.abort = 1'b1;
    end else if (stopDet) begin
      stNext    = ST_IDLE;
      cmd.abort = 1'b1;
    end else begin
      case (st)
        ST_ADDR: begin
          if (sclRise) begin
            cmd.shiftIn = 1'b1;
            cntNext     = bitCnt + 4'd1;
          end else if (sclFall && bitCnt == 4'd8) begin
            if (shByte[7:1] == SLV_ADDR) begin
              stNext     = ST_AACK;
              cmd.ackLow = 1'b1;
              rwNext     = shByte[0];
            end else begin
              stNext = ST_IDLE;
            end
          end
        end
        ST_AACK: begin
          if (sclFall) begin
            cntNext = 4'd0;
            if (rwBit) begin
              stNext       = ST_RD;
              cmd.loadRead = 1'b1;
            end else begin
              stNext     = ST_WR;
              cmd.relBus = 1'b1;
              firstNext  = 1'b1;
            end
          end
        end
        ST_WR: begin
          if (sclRise) begin
            cmd.shiftIn = 1'b1;
            cntNext     = bitCnt + 4'd1;
          end else if (sclFall && bitCnt == 4'd8) begin
            cmd.setPtr = firstWr;
            cmd.wrReg  = ~firstWr;
            firstNext  = 1'b0;
            cmd.ackLow = 1'b1;
            stNext     = ST_WACK;
          end
        end
        ST_WACK: begin
          if (sclFall) begin
            cmd.relBus = 1'b1;
            cntNext    = 4'd0;
            stNext     = ST_WR;
          end
        end
        ST_RD: begin
          if (sclRise) begin
            cntNext = bitCnt + 4'd1;
          end else if (sclFall) begin
            if (bitCnt == 4'd8) begin
              cmd.relBus = 1'b1;
              stNext     = ST_RACK;
            end else if (bitCnt != 4'd0) begin
              cmd.shiftOut = 1'b1;
            end
          end
        end
        ST_RACK: begin
          if (sclRise) begin
            mNackNext = sdaF;
          end else if (sclFall) begin
            if (!mNack) begin
              cmd.loadRead = 1'b1;
              cntNext      = 4'd0;
              stNext       = ST_RD;
            end else begin
              stNext = ST_WAIT;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      st      <= ST_IDLE;
      bitCnt  <= 4'd0;
      sclD    <= 1'b1;
      sdaD    <= 1'b1;
      rwBit   <= 1'b0;
      firstWr <= 1'b0;
      mNack   <= 1'b0;
    end else begin
      st      <= stNext;
      bitCnt  <= cntNext;
      sclD    <= sclF;
      sdaD    <= sdaF;
      rwBit   <= rwNext;
      firstWr <= firstNext;
      mNack   <= mNackNext;
    end
  end

  // R2
  start_restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    startDet |=> (st == ST_ADDR && bitCnt == 4'd0));
  // R2
  stop_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    stopDet |=> st == ST_IDLE);
  // R9
  one_drive_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({cmd.loadRead, cmd.shiftOut, cmd.ackLow, cmd.relBus}));
endmodule

// File: rtl/tw_datapath.sv
module tw_datapath
  import tw_pkg::*;
#(
  parameter int HOLD_CYC = 30,
  parameter int PTR_W    = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  twCmd_t            cmd,
  input  logic              sdaBit,
  input  logic [BYTE_W-1:0] regRdData,
  output logic [BYTE_W-1:0] shByte,
  output logic              sdaOe,
  output logic [PTR_W-1:0]  regAddr,
  output logic              regWrEn,
  output logic [BYTE_W-1:0] regWrData,
  output logic              regRdEn
);
  localparam int HW = $clog2(HOLD_CYC + 1);

  logic [BYTE_W-1:0] shReg;
  logic [PTR_W-1:0]  ptr;
  logic [HW-1:0]     holdCnt;
  logic              holdBusy, pendOe;
  logic              newDrive, newVal;

  assign newDrive = cmd.loadRead | cmd.shiftOut | cmd.ackLow | cmd.relBus;

  always_comb begin
    newVal = 1'b0;
    if (cmd.ackLow)        newVal = 1'b1;
    else if (cmd.loadRead) newVal = ~regRdData[BYTE_W-1];
    else if (cmd.shiftOut) newVal = ~shReg[BYTE_W-2];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shReg    <= '0;
      ptr      <= '0;
      holdCnt  <= '0;
      holdBusy <= 1'b0;
      pendOe   <= 1'b0;
      sdaOe    <= 1'b0;
    end else begin
      if (cmd.shiftIn)       shReg <= {shReg[BYTE_W-2:0], sdaBit};
      else if (cmd.loadRead) shReg <= regRdData;
      else if (cmd.shiftOut) shReg <= {shReg[BYTE_W-2:0], 1'b0};

      if (cmd.setPtr)                      ptr <= PTR_W'(shReg);
      else if (cmd.wrReg || cmd.loadRead)  ptr <= ptr + 1'b1;

      if (cmd.abort) begin
        holdBusy <= 1'b0;
        sdaOe    <= 1'b0;
      end else if (newDrive) begin
        pendOe   <= newVal;
        holdCnt  <= HW'(HOLD_CYC - 1);
        holdBusy <= 1'b1;
      end else if (holdBusy) begin
        if (holdCnt == '0) begin
          sdaOe    <= pendOe;
          holdBusy <= 1'b0;
        end else begin
          holdCnt <= holdCnt - 1'b1;
        end
      end
    end
  end

  assign shByte    = shReg;
  assign regAddr   = ptr;
  assign regWrEn   = cmd.wrReg;
  assign regWrData = shReg;
  assign regRdEn   = cmd.loadRead;

  // R5
  port_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(regWrEn && regRdEn));

  if (HOLD_CYC >= 2) begin : gHold
    // R9
    ack_delay_chk: assert property (@(posedge clk) disable iff (!rstN)
      cmd.ackLow |=> $stable(sdaOe));
  end
endmodule

// File: rtl/tw_slave.sv
module tw_slave
  import tw_pkg::*;
#(
  parameter logic [6:0] SLV_ADDR = 7'h2A,
  parameter int         FILT_CYC = 5,
  parameter int         HOLD_CYC = 30,
  parameter int         PTR_W    = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  output logic              sdaOe,
  output logic [PTR_W-1:0]  regAddr,
  output logic              regWrEn,
  output logic [BYTE_W-1:0] regWrData,
  output logic              regRdEn,
  input  logic [BYTE_W-1:0] regRdData
);
  localparam int N_WIRE = 2;

  logic [N_WIRE-1:0] rawBus, cleanBus;
  logic              sclF, sdaF;
  logic [BYTE_W-1:0] shByte;
  twCmd_t            cmd;

  assign rawBus = {sdaIn, sclIn};

  for (genvar g = 0; g < N_WIRE; g++) begin : gFilt
    tw_glitch_filter #(.FILT_CYC(FILT_CYC)) filt_i (
      .clk(clk), .rstN(rstN), .rawIn(rawBus[g]), .cleanOut(cleanBus[g]));
  end

  assign sclF = cleanBus[0];
  assign sdaF = cleanBus[1];

  tw_ctrl #(.SLV_ADDR(SLV_ADDR)) ctrl_i (
    .clk(clk), .rstN(rstN), .sclF(sclF), .sdaF(sdaF),
    .shByte(shByte), .cmd(cmd));

  tw_datapath #(.HOLD_CYC(HOLD_CYC), .PTR_W(PTR_W)) dp_i (
    .clk(clk), .rstN(rstN), .cmd(cmd), .sdaBit(sdaF),
    .regRdData(regRdData), .shByte(shByte), .sdaOe(sdaOe),
    .regAddr(regAddr), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdEn(regRdEn));

  // R10
  high_steady_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sclF && $past(sclF)) |-> ($stable(sdaOe) || !sdaOe));
endmodule

// File: tb/tw_slave_tb_top.sv
module tw_slave_tb_top;
  localparam int HOLD_CYC = 30;
  localparam int FILT_CYC = 5;
  localparam int HP = 150;
  localparam int Q  = 10;
  localparam int GL = FILT_CYC - 2;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rstN;
  logic sclDrv, sdaDrv, sclGlitch, sdaGlitch;
  logic sclBus, sdaBus;
  logic sdaOe, regWrEn, regRdEn;
  logic [7:0] regAddr, regWrData, regRdData;
  logic [7:0] mem [256];

  assign sclBus = sclDrv | sclGlitch;
  assign sdaBus = sdaDrv & ~sdaGlitch & ~sdaOe;
  assign regRdData = mem[regAddr];

  tw_slave #(.SLV_ADDR(7'h2A), .FILT_CYC(FILT_CYC), .HOLD_CYC(HOLD_CYC), .PTR_W(8)) dut_i (
    .clk(clk), .rstN(rstN), .sclIn(sclBus), .sdaIn(sdaBus), .sdaOe(sdaOe),
    .regAddr(regAddr), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdEn(regRdEn), .regRdData(regRdData));

  // ---------------- monitor: register port model and per-clock timing compare
  int chkMon, failMon, gotN, rdCount, oeCount, holdLeft;
  int gotAddr [64];
  int gotData [64];
  logic prevScl, prevOe, oeRef, holdBad, highBad;

  always @(negedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 256; i++) mem[i] = 8'((i * 37 + 11) & 255);
      chkMon = 0; failMon = 0; gotN = 0; rdCount = 0; oeCount = 0;
      holdLeft = 0; prevScl = 1'b1; prevOe = 1'b0; oeRef = 1'b0;
      holdBad = 1'b0; highBad = 1'b0;
    end else begin
      if (regWrEn) begin
        if (gotN < 64) begin gotAddr[gotN] = int'(regAddr); gotData[gotN] = int'(regWrData); end
        gotN++;
        mem[regAddr] = regWrData;
      end
      if (regRdEn) rdCount++;
      if (sdaOe) oeCount++;
      if (prevScl && !sclDrv) begin
        // R10 verdict for the high phase just ended
        chkMon++;
        if (highBad) begin
          failMon++;
          $display("FAIL R10 sdaOe rose while clock high: actual=1 expected=0");
        end
        // R9 window opens
        chkMon++;
        holdLeft = HOLD_CYC; oeRef = sdaOe; holdBad = 1'b0;
      end else if (holdLeft > 0) begin
        if (sdaOe != oeRef && !holdBad) begin
          holdBad = 1'b1; failMon++;
          $display("FAIL R9 sdaOe changed %0d cycles after clock fall: actual=%0d expected=%0d",
                   HOLD_CYC - holdLeft + 1, sdaOe, oeRef);
        end
        holdLeft--;
      end
      if (!prevScl && sclDrv) highBad = 1'b0;
      else if (prevScl && sclDrv && sdaOe && !prevOe) highBad = 1'b1;
      prevScl = sclDrv; prevOe = sdaOe;
    end
  end

  // ---------------- master side and reference
  int chkMain = 0, failMain = 0, wIdx = 0, ptrModel = 0;
  logic [7:0] refMem [256];

  task automatic chk(input string tag, input int act, input int exp);
    chkMain++;
    if (act != exp) begin
      failMain++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic busStart();
    if (!sclDrv) begin sdaDrv = 1'b1; tick(HP); sclDrv = 1'b1; end
    tick(HP); sdaDrv = 1'b0; tick(HP); sclDrv = 1'b0; tick(Q);
  endtask

  task automatic busStop();
    sdaDrv = 1'b0; tick(HP); sclDrv = 1'b1; tick(HP); sdaDrv = 1'b1; tick(HP);
  endtask

  task automatic bitOut(input logic b, input logic glitch, output logic seen);
    sdaDrv = b;
    if (glitch) begin
      tick(40); sclGlitch = 1'b1; tick(GL); sclGlitch = 1'b0; tick(HP - Q - 40 - GL);
    end else tick(HP - Q);
    sclDrv = 1'b1;
    tick(HP / 2);
    seen = sdaBus;
    if (glitch && b) begin
      sdaGlitch = 1'b1; tick(GL); sdaGlitch = 1'b0; tick(HP / 2 - GL);
    end else tick(HP / 2);
    sclDrv = 1'b0;
    tick(Q);
  endtask

  task automatic sendByte(input logic [7:0] b, input logic glitch, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) bitOut(b[i], glitch, s);
    bitOut(1'b1, 1'b0, s);
    ack = ~s;
  endtask

  task automatic recvByte(input logic ackIt, output logic [7:0] v);
    logic s;
    for (int i = 7; i >= 0; i--) begin bitOut(1'b1, 1'b0, s); v[i] = s; end
    bitOut(~ackIt, 1'b0, s);
  endtask

  task automatic expectWr(input string tag, input int a, input int d);
    chk({tag, " write addr"}, gotAddr[wIdx], a);
    chk({tag, " write data"}, gotData[wIdx], d);
    wIdx++;
  endtask

  task automatic runAll();
    logic ack;
    logic [7:0] v;
    int snapRd, snapOe, snapWr;
    logic s;

    tick(3); rstN = 1'b1; tick(2);
    chk("R1 sdaOe after reset", sdaOe, 0);
    chk("R1 regWrEn after reset", regWrEn, 0);
    chk("R1 regRdEn after reset", regRdEn, 0);

    // write: pointer 0x10, then two bytes
    busStart();
    sendByte(8'h54, 1'b0, ack); chk("R3 address ack", ack, 1);
    sendByte(8'h10, 1'b0, ack); chk("R5 pointer byte ack", ack, 1); ptrModel = 'h10;
    sendByte(8'hA5, 1'b0, ack); chk("R5 data ack", ack, 1); refMem[ptrModel] = 8'hA5; ptrModel++;
    sendByte(8'h3C, 1'b0, ack); chk("R5 data ack", ack, 1); refMem[ptrModel] = 8'h3C; ptrModel++;
    busStop();
    expectWr("R5", 'h10, 'hA5);
    expectWr("R5", 'h11, 'h3C);
    chk("R5 write count", gotN, wIdx);

    // write pointer, repeated START, read three bytes
    snapRd = rdCount;
    busStart();
    sendByte(8'h54, 1'b0, ack); chk("R3 address ack", ack, 1);
    sendByte(8'h10, 1'b0, ack); chk("R5 pointer ack", ack, 1); ptrModel = 'h10;
    busStart();
    sendByte(8'h55, 1'b0, ack); chk("R11 read address ack after repeated start", ack, 1);
    recvByte(1'b1, v); chk("R6 read byte 0", v, refMem[ptrModel]); ptrModel++;
    recvByte(1'b1, v); chk("R6 read byte 1", v, refMem[ptrModel]); ptrModel++;
    recvByte(1'b0, v); chk("R6 read byte 2", v, refMem[ptrModel]); ptrModel++;
    busStop();
    chk("R6 read strobes", rdCount - snapRd, 3);

    // mismatched address
    snapRd = rdCount; snapOe = oeCount; snapWr = gotN;
    busStart();
    sendByte(8'h56, 1'b0, ack); chk("R4 foreign address not acked", ack, 0);
    sendByte(8'h10, 1'b0, ack); chk("R4 data not acked", ack, 0);
    sendByte(8'h99, 1'b0, ack); chk("R4 data not acked", ack, 0);
    busStop();
    chk("R4 no pull", oeCount - snapOe, 0);
    chk("R4 no reads", rdCount - snapRd, 0);
    chk("R4 no writes", gotN - snapWr, 0);

    // read continues from pointer, NACK, extra clocks ignored
    busStart();
    sendByte(8'h55, 1'b0, ack); chk("R3 read address ack", ack, 1);
    recvByte(1'b0, v); chk("R6 read continues at pointer", v, refMem[ptrModel]); ptrModel++;
    snapRd = rdCount; snapOe = oeCount;
    recvByte(1'b1, v);
    chk("R7 wire released after nack", v, 'hFF);
    chk("R7 no pull after nack", oeCount - snapOe, 0);
    chk("R7 no reads after nack", rdCount - snapRd, 0);
    busStop();

    // byte cut short by STOP
    snapWr = gotN;
    busStart();
    sendByte(8'h54, 1'b0, ack); chk("R3 address ack", ack, 1);
    bitOut(1'b1, 1'b0, s); bitOut(1'b0, 1'b0, s); bitOut(1'b1, 1'b0, s);
    busStop();
    chk("R2 stop abandons partial byte", gotN - snapWr, 0);

    // glitches on both wires during a write
    busStart();
    sendByte(8'h54, 1'b0, ack); chk("R2 address ack after aborted transfer", ack, 1);
    sendByte(8'h40, 1'b1, ack); chk("R8 pointer ack under glitches", ack, 1); ptrModel = 'h40;
    sendByte(8'h81, 1'b1, ack); chk("R8 data ack under glitches", ack, 1); refMem[ptrModel] = 8'h81; ptrModel++;
    sendByte(8'h7E, 1'b1, ack); chk("R8 data ack under glitches", ack, 1); refMem[ptrModel] = 8'h7E; ptrModel++;
    busStop();
    expectWr("R8", 'h40, 'h81);
    expectWr("R8", 'h41, 'h7E);
    chk("R8 write count", gotN, wIdx);

    // read back
    busStart();
    sendByte(8'h54, 1'b0, ack); chk("R3 address ack", ack, 1);
    sendByte(8'h40, 1'b0, ack); chk("R5 pointer ack", ack, 1); ptrModel = 'h40;
    busStart();
    sendByte(8'h55, 1'b0, ack); chk("R11 read address ack", ack, 1);
    recvByte(1'b1, v); chk("R8 readback 0", v, refMem[ptrModel]); ptrModel++;
    recvByte(1'b0, v); chk("R8 readback 1", v, refMem[ptrModel]); ptrModel++;
    busStop();
    chk("R1 bus released at end", sdaOe, 0);
  endtask

  initial begin
    rstN = 1'b0; sclDrv = 1'b1; sdaDrv = 1'b1; sclGlitch = 1'b0; sdaGlitch = 1'b0;
    for (int i = 0; i < 256; i++) refMem[i] = 8'((i * 37 + 11) & 255);
    fork
      runAll();
      begin
        tick(190000);
        failMain++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    disable fork;
    $display("End of test - %0d assertions evaluated, %0d failures",
             chkMain + chkMon, failMain + failMon);
    $finish;
  end
endmodule